// File: doc/BRIEF.md
# Encoder Operating Mode Controller

This block is the mode sequencer at the top of a streaming audio/video encoder. A host issues one of eight commands on a small command port. The controller moves the encoder between five operating modes: Idle, Stop, Encode, Paused and Power-down. From the current mode it drives three enables: one for input processing, one for the output multiplexer and one for the internal clock. The encoding datapath sits outside this block and only follows those enables.

Stop and pause do not take effect at once. The controller stays in Encode, with the output still running, until the datapath reports that the current group of pictures and audio frame have closed. It then signals either an end-of-sequence append (for stop) or a save of the buffer-model context (for pause). During every multi-cycle transition the controller reports busy and ignores ordinary commands. A forced reconfigure is accepted even then, so the host can escape a drain that never completes because the input has disappeared. A programmable timeout flags a drain that has lasted too long.

The controller also holds the configuration register bank. It decides which registers can be written in the present mode. A completion flag drives an active-low interrupt that the host can mask.

Top module: `enc_mode_ctrl`

## Requirements
- R1: On hard reset (`rst` high at a clock edge) the controller enters Idle. Idle reports `mode_o` = 0, where the mode codes are 0 Idle, 1 Stop, 2 Encode, 3 Paused and 4 Power-down. After reset `busy_o`, `in_proc_en`, `mux_out_en`, `done_flag` and `err_timeout` are 0, `clk_en` is 1 and `irq_n` is 1. Every configuration register k returns to its default value 0x10 + k.
- R2: Command codes on `cmd_code`, taken when `cmd_valid` is high at a clock edge, are: 0 soft reset, 1 reconfigure, 2 enable, 3 start, 4 stop, 5 pause, 6 sleep, 7 forced reconfigure. Enable in Idle moves to Stop on that edge. In Stop, `in_proc_en` is 1 and `mux_out_en` is 0.
- R3: Start in Stop or Paused moves to Encode on that edge, with `mux_out_en` and `in_proc_en` at 1. Start in Idle first spends one cycle in a transient step that reports mode Stop with `busy_o` at 1 and `mux_out_en` at 0. Encode follows on the next edge.
- R4: Stop in Encode holds mode Encode with `busy_o` and `mux_out_en` at 1 until `gop_done` is seen high at an edge. On that edge the mode becomes Stop, and `eos_req` is high for exactly the following cycle.
- R5: Pause in Encode drains in the same way as stop. On completion it enters Paused, with `in_proc_en` 1 and `mux_out_en` 0. `ctx_save` pulses for one cycle and `eos_req` stays 0. A later start returns to Encode.
- R6: While `busy_o` is 1, every command other than soft reset and forced reconfigure is ignored. A command that has no meaning in the current stable mode is also ignored, leaves the mode unchanged and does not set `done_flag`.
- R7: Soft reset is accepted in every mode except Power-down. It goes to Idle and restores every configuration register to its default. Reconfigure in Stop or Paused goes to Idle and leaves the configuration unchanged.
- R8: Sleep in Idle enters Power-down. There `clk_en`, `in_proc_en` and `mux_out_en` are 0 and every command is ignored. Only a hard reset leaves this mode.
- R9: Forced reconfigure is accepted in every mode except Power-down and during a forced reconfigure already under way. It spends RESTORE_CYC cycles (8 by default) reporting mode Idle with `busy_o` 1 and both enables 0, without waiting for `gop_done`. It then settles in Idle with `busy_o` 0 and the configuration unchanged.
- R10: The drain step of a stop or pause counts its cycles. If the step is still waiting after `timeout_limit` + 1 edges, `err_timeout` sets and stays set until an edge with `stat_clr[1]` high. The drain itself continues.
- R11: Each completed transition sets `done_flag`. `irq_n` is 0 exactly when `done_flag` is 1 and `irq_mask` is 0. An edge with `stat_clr[0]` high clears `done_flag`.
- R12: Registers with index below NUM_DYN (2 by default) are dynamic and can be written in Idle, Stop, Encode and Paused while not busy. All other registers can be written only in Idle. Any other write is ignored. `cfg_rdata` returns the register selected by `cfg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hard reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code |
| gop_done | input | 1 | Current GOP and audio frame have closed |
| timeout_limit | input | TO_W | Drain timeout limit in cycles |
| stat_clr | input | 2 | Write-one clear: bit 0 done flag, bit 1 timeout error |
| irq_mask | input | 1 | Masks the completion interrupt when high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | AW | Configuration register index for write and read |
| cfg_wdata | input | DATA_W | Configuration write data |
| cfg_rdata | output | DATA_W | Configuration read data |
| mode_o | output | 3 | Reported operating mode |
| busy_o | output | 1 | Transition under way |
| in_proc_en | output | 1 | Input processing enable |
| mux_out_en | output | 1 | Output multiplexer enable |
| clk_en | output | 1 | Internal clock enable |
| eos_req | output | 1 | One-cycle request to append end-of-sequence |
| ctx_save | output | 1 | One-cycle request to save buffer-model context |
| done_flag | output | 1 | Transition-complete status |
| err_timeout | output | 1 | Drain timeout status |
| irq_n | output | 1 | Active-low completion interrupt |

## Verification
The bench checks that a stop keeps the output running while it waits for `gop_done`, and that exactly one end-of-sequence pulse comes out when the drain ends. A design that gated the output at once would truncate the stream, and one that kept the pulse high would append the marker twice. A pause is checked for the context-save pulse and the absence of the end-of-sequence pulse. A start from Idle is checked for its one-cycle detour through Stop. Commands sent during a drain, and a command with no meaning in Idle, must change nothing. The bench also checks that a forced reconfigure breaks out of a drain that never ends, keeps the written configuration, and holds the enables off for its full restore window. Power-down must refuse even a soft reset, and a static register must refuse writes outside Idle.

// File: rtl/enc_mode_pkg.sv
package enc_mode_pkg;

    typedef enum logic [2:0] {
        CMD_SOFT_RST = 3'd0,
        CMD_RECONF   = 3'd1,
        CMD_ENABLE   = 3'd2,
        CMD_START    = 3'd3,
        CMD_STOP     = 3'd4,
        CMD_PAUSE    = 3'd5,
        CMD_SLEEP    = 3'd6,
        CMD_FORCE    = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        MODE_IDLE   = 3'd0,
        MODE_STOP   = 3'd1,
        MODE_ENCODE = 3'd2,
        MODE_PAUSED = 3'd3,
        MODE_PWRDN  = 3'd4
    } mode_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STOP,
        S_ENCODE,
        S_PAUSED,
        S_PWRDN,
        S_PRE_ENC,
        S_DRAIN_STOP,
        S_DRAIN_PAUSE,
        S_RESTORE
    } state_e;

    typedef struct packed {
        logic in_proc;
        logic mux_out;
        logic clk_on;
    } ctrl_t;

    function automatic mode_e report_mode(state_e s);
        case (s)
            S_STOP, S_PRE_ENC:                 return MODE_STOP;
            S_ENCODE, S_DRAIN_STOP,
            S_DRAIN_PAUSE:                     return MODE_ENCODE;
            S_PAUSED:                          return MODE_PAUSED;
            S_PWRDN:                           return MODE_PWRDN;
            default:                           return MODE_IDLE;
        endcase
    endfunction

    function automatic ctrl_t ctrl_of(state_e s);
        ctrl_t c;
        c.clk_on  = (s != S_PWRDN);
        c.in_proc = (s == S_STOP) || (s == S_PRE_ENC) || (s == S_ENCODE) ||
                    (s == S_PAUSED) || (s == S_DRAIN_STOP) || (s == S_DRAIN_PAUSE);
        c.mux_out = (s == S_ENCODE) || (s == S_DRAIN_STOP) || (s == S_DRAIN_PAUSE);
        return c;
    endfunction

    function automatic logic is_busy(state_e s);
        return (s == S_PRE_ENC) || (s == S_DRAIN_STOP) ||
               (s == S_DRAIN_PAUSE) || (s == S_RESTORE);
    endfunction

    function automatic logic is_draining(state_e s);
        return (s == S_DRAIN_STOP) || (s == S_DRAIN_PAUSE);
    endfunction

    function automatic logic [31:0] cfg_default(int unsigned k);
        return 32'h10 + 32'(k);
    endfunction

endpackage

// File: rtl/enc_cmd_fsm.sv
module enc_cmd_fsm
    import enc_mode_pkg::*;
#(
    parameter int TO_W        = 16,
    parameter int RESTORE_CYC = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_code,
    input  logic            gop_done,
    input  logic [TO_W-1:0] timeout_limit,
    input  logic            err_clr,
    output state_e          state_o,
    output logic            done_evt,
    output logic            soft_rst_evt,
    output logic            eos_req,
    output logic            ctx_save,
    output logic            err_timeout
);

    localparam logic [TO_W-1:0] RESTORE_LAST = TO_W'(RESTORE_CYC - 1);

    state_e          state_q, state_d;
    logic [TO_W-1:0] cnt_q;
    logic            eos_q, ctx_q, err_q;
    cmd_e            cmd;

    assign cmd = cmd_e'(cmd_code);

    always_comb begin
        state_d      = state_q;
        done_evt     = 1'b0;
        soft_rst_evt = 1'b0;
        if (cmd_valid && cmd == CMD_SOFT_RST && state_q != S_PWRDN) begin
            state_d      = S_IDLE;
            done_evt     = 1'b1;
            soft_rst_evt = 1'b1;
        end else if (cmd_valid && cmd == CMD_FORCE &&
                     state_q != S_PWRDN && state_q != S_RESTORE) begin
            state_d = S_RESTORE;
        end else begin
            case (state_q)
                S_IDLE: if (cmd_valid) begin
                    case (cmd)
                        CMD_ENABLE: begin state_d = S_STOP;  done_evt = 1'b1; end
                        CMD_START:  state_d = S_PRE_ENC;
                        CMD_RECONF: begin state_d = S_IDLE;  done_evt = 1'b1; end
                        CMD_SLEEP:  begin state_d = S_PWRDN; done_evt = 1'b1; end
                        default: ;
                    endcase
                end
                S_STOP, S_PAUSED: if (cmd_valid) begin
                    case (cmd)
                        CMD_START:  begin state_d = S_ENCODE; done_evt = 1'b1; end
                        CMD_RECONF: begin state_d = S_IDLE;   done_evt = 1'b1; end
                        default: ;
                    endcase
                end
                S_ENCODE: if (cmd_valid) begin
                    case (cmd)
                        CMD_STOP:  state_d = S_DRAIN_STOP;
                        CMD_PAUSE: state_d = S_DRAIN_PAUSE;
                        default: ;
                    endcase
                end
                S_PRE_ENC: begin
                    state_d  = S_ENCODE;
                    done_evt = 1'b1;
                end
                S_DRAIN_STOP: if (gop_done) begin
                    state_d  = S_STOP;
                    done_evt = 1'b1;
                end
                S_DRAIN_PAUSE: if (gop_done) begin
                    state_d  = S_PAUSED;
                    done_evt = 1'b1;
                end
                S_RESTORE: if (cnt_q == RESTORE_LAST) begin
                    state_d  = S_IDLE;
                    done_evt = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            eos_q   <= 1'b0;
            ctx_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            eos_q   <= (state_q == S_DRAIN_STOP)  && (state_d == S_STOP);
            ctx_q   <= (state_q == S_DRAIN_PAUSE) && (state_d == S_PAUSED);
            if (state_d != state_q)
                cnt_q <= '0;
            else if (state_q == S_RESTORE || (is_draining(state_q) && cnt_q != timeout_limit))
                cnt_q <= cnt_q + 1'b1;
            if (is_draining(state_q) && state_d == state_q && cnt_q == timeout_limit)
                err_q <= 1'b1;
            else if (err_clr)
                err_q <= 1'b0;
        end
    end

    assign state_o     = state_q;
    assign eos_req     = eos_q;
    assign ctx_save    = ctx_q;
    assign err_timeout = err_q;

    // R8: power-down is left only through hard reset
    p_pwrdn_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_PWRDN) |=> (state_q == S_PWRDN));

    // R4: end-of-sequence follows only a completed stop drain
    p_eos_origin_r4: assert property (@(posedge clk) disable iff (rst)
        eos_q |-> $past(state_q == S_DRAIN_STOP));

    // R4: a stop drain ends in Stop only after the handshake
    p_drain_needs_done_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q == S_DRAIN_STOP) && state_q == S_STOP) |-> $past(gop_done));

    // R5: context save follows only a completed pause drain
    p_ctx_origin_r5: assert property (@(posedge clk) disable iff (rst)
        ctx_q |-> $past(state_q == S_DRAIN_PAUSE));

endmodule

// File: rtl/enc_cfg_bank.sv
module enc_cfg_bank
    import enc_mode_pkg::*;
#(
    parameter int NUM_CFG = 8,
    parameter int NUM_DYN = 2,
    parameter int DATA_W  = 8,
    localparam int AW     = $clog2(NUM_CFG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              allow_dyn,
    input  logic              allow_static,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] regs [NUM_CFG];

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_reg
        logic wr_ok;
        if (k < NUM_DYN) begin : g_dyn
            assign wr_ok = allow_dyn;
        end else begin : g_static
            assign wr_ok = allow_static;

            // R12: static registers change only in Idle or on soft reset
            p_static_gate_r12: assert property (@(posedge clk) disable iff (rst)
                !$stable(regs[k]) |-> $past(allow_static || soft_rst));
        end

        always_ff @(posedge clk) begin
            if (rst || soft_rst)
                regs[k] <= DATA_W'(cfg_default(k));
            else if (wr_en && addr == AW'(k) && wr_ok)
                regs[k] <= wdata;
        end
    end

    assign rdata = (32'(addr) < NUM_CFG) ? regs[addr] : '0;

endmodule

// File: rtl/enc_irq_unit.sv
module enc_irq_unit (
    input  logic clk,
    input  logic rst,
    input  logic done_evt,
    input  logic clr,
    input  logic mask,
    output logic flag,
    output logic irq_n
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (done_evt)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    assign flag  = flag_q;
    assign irq_n = ~(flag_q & ~mask);

    // R11: the flag rises only on a completed transition
    p_flag_source_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(done_evt));

    // R11: the flag falls only on a clear
    p_flag_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(clr));

endmodule

// File: rtl/enc_mode_ctrl.sv
module enc_mode_ctrl
    import enc_mode_pkg::*;
#(
    parameter int NUM_CFG     = 8,
    parameter int NUM_DYN     = 2,
    parameter int DATA_W      = 8,
    parameter int TO_W        = 16,
    parameter int RESTORE_CYC = 8,
    localparam int AW         = $clog2(NUM_CFG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_code,
    input  logic              gop_done,
    input  logic [TO_W-1:0]   timeout_limit,
    input  logic [1:0]        stat_clr,
    input  logic              irq_mask,
    input  logic              cfg_wr,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [2:0]        mode_o,
    output logic              busy_o,
    output logic              in_proc_en,
    output logic              mux_out_en,
    output logic              clk_en,
    output logic              eos_req,
    output logic              ctx_save,
    output logic              done_flag,
    output logic              err_timeout,
    output logic              irq_n
);

    state_e state;
    ctrl_t  ctrl;
    logic   done_evt, soft_rst_evt;
    logic   allow_dyn, allow_static;

    enc_cmd_fsm #(.TO_W(TO_W), .RESTORE_CYC(RESTORE_CYC)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_code     (cmd_code),
        .gop_done     (gop_done),
        .timeout_limit(timeout_limit),
        .err_clr      (stat_clr[1]),
        .state_o      (state),
        .done_evt     (done_evt),
        .soft_rst_evt (soft_rst_evt),
        .eos_req      (eos_req),
        .ctx_save     (ctx_save),
        .err_timeout  (err_timeout)
    );

    assign ctrl         = ctrl_of(state);
    assign in_proc_en   = ctrl.in_proc;
    assign mux_out_en   = ctrl.mux_out;
    assign clk_en       = ctrl.clk_on;
    assign mode_o       = report_mode(state);
    assign busy_o       = is_busy(state);
    assign allow_static = (state == S_IDLE);
    assign allow_dyn    = (state == S_IDLE) || (state == S_STOP) ||
                          (state == S_ENCODE) || (state == S_PAUSED);

    enc_cfg_bank #(.NUM_CFG(NUM_CFG), .NUM_DYN(NUM_DYN), .DATA_W(DATA_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .soft_rst    (soft_rst_evt),
        .wr_en       (cfg_wr),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .allow_dyn   (allow_dyn),
        .allow_static(allow_static),
        .rdata       (cfg_rdata)
    );

    enc_irq_unit u_irq (
        .clk     (clk),
        .rst     (rst),
        .done_evt(done_evt),
        .clr     (stat_clr[0]),
        .mask    (irq_mask),
        .flag    (done_flag),
        .irq_n   (irq_n)
    );

    // R3: the multiplexer never runs without input processing
    p_mux_needs_input_r3: assert property (@(posedge clk) disable iff (rst)
        mux_out_en |-> in_proc_en);

    // R6: a busy step that is not a forced reconfigure stays busy or completes
    p_busy_no_new_drain_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(busy_o) && $past(mode_o) == 3'd2 && mode_o != 3'd2) |-> $past(gop_done || cmd_valid));

endmodule

// File: tb/enc_mode_ctrl_test.sv
module enc_mode_ctrl_test;
    import enc_mode_pkg::*;

    localparam int RCYC = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = 3'd0;
    logic        gop_done = 1'b0;
    logic [15:0] timeout_limit = 16'd1000;
    logic [1:0]  stat_clr = 2'b00;
    logic        irq_mask = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = 3'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic [7:0]  cfg_rdata;
    logic [2:0]  mode_o;
    logic        busy_o, in_proc_en, mux_out_en, clk_en, eos_req, ctx_save;
    logic        done_flag, err_timeout, irq_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    enc_mode_ctrl uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .gop_done(gop_done), .timeout_limit(timeout_limit), .stat_clr(stat_clr),
        .irq_mask(irq_mask), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mode_o(mode_o),
        .busy_o(busy_o), .in_proc_en(in_proc_en), .mux_out_en(mux_out_en),
        .clk_en(clk_en), .eos_req(eos_req), .ctx_save(ctx_save),
        .done_flag(done_flag), .err_timeout(err_timeout), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input cmd_e c);
        @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        cfg_addr = a; #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic gop_pulse();
        @(negedge clk); gop_done = 1'b1;
        @(negedge clk); gop_done = 1'b0;
    endtask

    task automatic clr(input logic [1:0] b);
        @(negedge clk); stat_clr = b;
        @(negedge clk); stat_clr = 2'b00;
    endtask

    task automatic hard_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mode", mode_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 in_proc", in_proc_en, 0);
        chk("R1 mux", mux_out_en, 0);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 done", done_flag, 0);
        chk("R1 err", err_timeout, 0);
        rd_chk("R1 default reg3", 3'd3, 8'h13);
    endtask

    task automatic t_enable_cfg();
        wr(3'd5, 8'hA5);
        rd_chk("R12 static write in Idle", 3'd5, 8'hA5);
        send(CMD_ENABLE);
        chk("R2 mode Stop", mode_o, 1);
        chk("R2 in_proc", in_proc_en, 1);
        chk("R2 mux off", mux_out_en, 0);
        wr(3'd5, 8'h5A);
        rd_chk("R12 static write in Stop ignored", 3'd5, 8'hA5);
        wr(3'd1, 8'h77);
        rd_chk("R12 dynamic write in Stop", 3'd1, 8'h77);
    endtask

    task automatic t_start_stop();
        send(CMD_START);
        chk("R3 Stop->Encode mode", mode_o, 2);
        chk("R3 mux on", mux_out_en, 1);
        chk("R3 not busy", busy_o, 0);
        send(CMD_STOP);
        chk("R4 drain busy", busy_o, 1);
        chk("R4 drain mode", mode_o, 2);
        chk("R4 drain mux on", mux_out_en, 1);
        repeat (3) @(negedge clk);
        send(CMD_ENABLE);
        chk("R6 cmd ignored while busy", busy_o, 1);
        wr(3'd0, 8'h99);
        rd_chk("R12 dynamic write while busy ignored", 3'd0, 8'h10);
        gop_pulse();
        chk("R4 mode Stop", mode_o, 1);
        chk("R4 busy cleared", busy_o, 0);
        chk("R4 eos pulse", eos_req, 1);
        chk("R4 mux off", mux_out_en, 0);
        @(negedge clk);
        chk("R4 eos one cycle", eos_req, 0);
    endtask

    task automatic t_idle_start();
        send(CMD_RECONF);
        chk("R7 reconf to Idle", mode_o, 0);
        rd_chk("R7 reconf keeps cfg", 3'd5, 8'hA5);
        send(CMD_START);
        chk("R3 transient mode Stop", mode_o, 1);
        chk("R3 transient busy", busy_o, 1);
        chk("R3 transient mux off", mux_out_en, 0);
        chk("R3 transient in_proc", in_proc_en, 1);
        @(negedge clk);
        chk("R3 reaches Encode", mode_o, 2);
        chk("R3 Encode not busy", busy_o, 0);
        chk("R3 Encode mux", mux_out_en, 1);
    endtask

    task automatic t_pause();
        send(CMD_PAUSE);
        chk("R5 pause drain busy", busy_o, 1);
        chk("R5 pause drain mux", mux_out_en, 1);
        gop_pulse();
        chk("R5 mode Paused", mode_o, 3);
        chk("R5 ctx_save", ctx_save, 1);
        chk("R5 no eos", eos_req, 0);
        chk("R5 mux off", mux_out_en, 0);
        chk("R5 in_proc on", in_proc_en, 1);
        @(negedge clk);
        chk("R5 ctx_save one cycle", ctx_save, 0);
        send(CMD_START);
        chk("R5 resume Encode", mode_o, 2);
    endtask

    task automatic t_irq();
        clr(2'b01);
        chk("R11 flag cleared", done_flag, 0);
        chk("R11 irq idle", irq_n, 1);
        irq_mask = 1'b1;
        send(CMD_STOP);
        gop_pulse();
        chk("R11 flag set", done_flag, 1);
        chk("R11 irq masked", irq_n, 1);
        irq_mask = 1'b0; #1;
        chk("R11 irq asserted", irq_n, 0);
        clr(2'b01);
        chk("R11 irq released", irq_n, 1);
    endtask

    task automatic t_timeout_force();
        timeout_limit = 16'd20;
        send(CMD_START);
        send(CMD_STOP);
        repeat (19) @(negedge clk);
        chk("R10 no early timeout", err_timeout, 0);
        repeat (3) @(negedge clk);
        chk("R10 timeout flagged", err_timeout, 1);
        chk("R10 drain continues", busy_o, 1);
        send(CMD_FORCE);
        chk("R9 restore busy", busy_o, 1);
        chk("R9 restore mode Idle", mode_o, 0);
        chk("R9 restore in_proc off", in_proc_en, 0);
        chk("R9 restore mux off", mux_out_en, 0);
        repeat (RCYC - 1) @(negedge clk);
        chk("R9 restore full window", busy_o, 1);
        @(negedge clk);
        chk("R9 restore done", busy_o, 0);
        chk("R9 settles Idle", mode_o, 0);
        rd_chk("R9 cfg kept", 3'd1, 8'h77);
        chk("R10 error sticky", err_timeout, 1);
        clr(2'b10);
        chk("R10 error cleared", err_timeout, 0);
        timeout_limit = 16'd1000;
    endtask

    task automatic t_soft_illegal();
        send(CMD_ENABLE);
        send(CMD_SOFT_RST);
        chk("R7 soft reset to Idle", mode_o, 0);
        rd_chk("R7 defaults restored reg5", 3'd5, 8'h15);
        rd_chk("R7 defaults restored reg1", 3'd1, 8'h11);
        clr(2'b01);
        send(CMD_STOP);
        chk("R6 illegal cmd mode", mode_o, 0);
        chk("R6 illegal cmd no done", done_flag, 0);
    endtask

    task automatic t_sleep();
        send(CMD_SLEEP);
        chk("R8 mode Power-down", mode_o, 4);
        chk("R8 clock off", clk_en, 0);
        chk("R8 input off", in_proc_en, 0);
        send(CMD_SOFT_RST);
        chk("R8 soft reset ignored", mode_o, 4);
        send(CMD_ENABLE);
        chk("R8 enable ignored", mode_o, 4);
        hard_reset();
        chk("R8 hard reset leaves", mode_o, 0);
        chk("R1 clock back", clk_en, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_cfg();
        t_start_stop();
        t_idle_start();
        t_pause();
        t_irq();
        t_timeout_force();
        t_soft_illegal();
        t_sleep();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule